// File: doc/BRIEF.md
# Reset Source Capture Controller

This block keeps a record of which reset source was behind the most recent reset and controls when the internal reset is released. It takes four reset event strobes: power-on, supply brown-out, external pin and watchdog time-out. All four arrive already synchronized to `clk`. A watchdog time-out is turned into a reset pulse one clock wide. Every active source, including that pulse, loads a release counter. The counter keeps the internal reset asserted for a set number of cycles after the last source goes away.

Four sticky cause flags sit in one status byte that software reads and writes through a simple register port. The flag registers are not cleared by the internal reset, so after a reset software can still read which source caused it. Only the power-on event initializes them. Bit 6 of the byte is a general-purpose read/write bit and has no link to the flag logic. Bits 7, 5 and 4 always read as zero.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A rising edge on `wdt_evt` produces exactly one `wdt_pulse` cycle, one clock after the edge is sampled, however long `wdt_evt` stays high.
- R2: The release countdown starts at the clock edge where `wdt_pulse` falls, and `int_rst` is high from that edge for DELAY_CYC further cycles.
- R3: The status byte layout is: bit 3 watchdog flag, bit 2 brown-out flag, bit 1 external flag, bit 0 power-on flag, bit 6 general-purpose bit; bits 7, 5 and 4 read as 0.
- R4: A brown-out event, an external event or a watchdog pulse sets its own flag. Flags from different sources accumulate while software does not clear them.
- R5: A power-on event sets the power-on flag and clears the watchdog, brown-out and external flags and the general-purpose bit.
- R6: A write (`wr_en` high) with a 0 in a flag bit position clears that flag. A 1 in that position leaves the flag unchanged. The power-on flag is cleared only this way.
- R7: If a flag's set event and a software clear of that flag happen in the same cycle, the flag ends up set.
- R8: Bit 6 takes the written value on every write and is independent of the flag bits and of reset events other than power-on.
- R9: `int_rst` is high in every cycle after an edge where any source (power-on, brown-out, external, watchdog pulse) was sampled active. It stays high for DELAY_CYC more cycles after the last such edge and then falls.
- R10: The flags and bit 6 are unaffected by `int_rst`. Their state is readable while the internal reset is held and after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_evt | input | 1 | Power-on reset event, synchronous, active high |
| bor_evt | input | 1 | Brown-out reset event, active high |
| ext_evt | input | 1 | External pin reset event, active high |
| wdt_evt | input | 1 | Watchdog time-out strobe, active high |
| wr_en | input | 1 | Status byte write strobe |
| wr_data | input | 8 | Status byte write data |
| rd_data | output | 8 | Status byte read data |
| wdt_pulse | output | 1 | One-cycle watchdog reset pulse |
| int_rst | output | 1 | Internal reset, active high |

## Verification
The assertions assume that `por_evt` is high at the first clock edge, because no register has a defined value until then. They also assume every event input is a clean synchronous level that changes only between edges. The stimulus raises `por_evt` before the first edge and drives every input on the falling clock edge. Watchdog strobes are sometimes held for several cycles, which tests the edge detection without breaking these assumptions. A brown-out strobe is issued in the same cycle as a clearing write to test the set-over-clear priority.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
    localparam int FLAG_N   = 4;
    localparam int BIT_WDF  = 3;
    localparam int BIT_BRF  = 2;
    localparam int BIT_EXF  = 1;
    localparam int BIT_PWF  = 0;
    localparam int BIT_GP   = 6;

    typedef struct packed {
        logic [FLAG_N-1:0] flg;
        logic              gp;
    } cause_st_t;
endpackage

// File: rtl/rc_wdt_pulse.sv
module rc_wdt_pulse (
    input  logic clk,
    input  logic por_evt,
    input  logic wdt_evt,
    output logic pulse
);
    typedef struct packed {
        logic prev;
        logic pls;
    } wp_st_t;

    wp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_evt) begin
            st_d.prev = 1'b0;
            st_d.pls  = 1'b0;
        end else begin
            st_d.prev = wdt_evt;
            st_d.pls  = wdt_evt & ~st_q.prev;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pulse = st_q.pls;

    // R1: never two consecutive pulse cycles
    a_r1_single_cycle: assert property (@(posedge clk) disable iff (por_evt)
        pulse |=> !pulse);
    // R1: pulse follows a sampled rising edge of the strobe
    a_r1_from_edge: assert property (@(posedge clk) disable iff (por_evt)
        $rose(pulse) |-> $past(wdt_evt));
endmodule

// File: rtl/rc_release_timer.sv
module rc_release_timer #(
    parameter int DELAY_CYC = 4096
) (
    input  logic clk,
    input  logic src_any,
    output logic rst_out
);
    localparam int CNT_W = $clog2(DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst;
    } rt_st_t;

    rt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (src_any) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.rst = src_any | (st_q.cnt != '0);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rst_out = st_q.rst;

    // R9: countdown reloads whenever a source is seen
    a_r9_reload: assert property (@(posedge clk)
        src_any |=> (st_q.cnt == LOAD) && rst_out);
    // R9: reset only falls once the countdown is spent
    a_r9_release: assert property (@(posedge clk) disable iff (src_any)
        $fell(rst_out) |-> (st_q.cnt == '0));
    // R9: counter never exceeds its load value
    a_r9_bound: assert property (@(posedge clk) disable iff (src_any)
        st_q.cnt <= LOAD);
endmodule

// File: rtl/rc_cause_flags.sv
module rc_cause_flags
    import rst_cause_pkg::*;
(
    input  logic       clk,
    input  logic       por_evt,
    input  logic       bor_evt,
    input  logic       ext_evt,
    input  logic       wdt_set,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    cause_st_t st_d, st_q;
    logic [FLAG_N-1:0] set_v;
    logic [FLAG_N-1:0] clr_v;

    always_comb begin
        set_v          = '0;
        set_v[BIT_WDF] = wdt_set;
        set_v[BIT_BRF] = bor_evt;
        set_v[BIT_EXF] = ext_evt;
        set_v[BIT_PWF] = por_evt;
        clr_v = '0;
        for (int i = 0; i < FLAG_N; i++) begin
            clr_v[i] = wr_en & ~wr_data[i];
        end

        st_d = st_q;
        for (int i = 0; i < FLAG_N; i++) begin
            if (set_v[i])      st_d.flg[i] = 1'b1;
            else if (clr_v[i]) st_d.flg[i] = 1'b0;
        end
        if (wr_en) st_d.gp = wr_data[BIT_GP];

        if (por_evt) begin
            st_d.flg          = '0;
            st_d.flg[BIT_PWF] = 1'b1;
            st_d.gp           = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_data         = '0;
        rd_data[3:0]    = st_q.flg;
        rd_data[BIT_GP] = st_q.gp;
    end

    // R5: power-on leaves only its own flag
    a_r5_por_init: assert property (@(posedge clk)
        por_evt |=> (st_q.flg == 4'b0001) && !st_q.gp);
    // R4/R7: a set event always wins over a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (por_evt)
        bor_evt |=> st_q.flg[BIT_BRF]);
    a_r4_ext_set: assert property (@(posedge clk) disable iff (por_evt)
        ext_evt |=> st_q.flg[BIT_EXF]);
    a_r4_wdt_set: assert property (@(posedge clk) disable iff (por_evt)
        wdt_set |=> st_q.flg[BIT_WDF]);
    // R6: without a zero write, the power-on flag cannot fall
    a_r6_pwf_sticky: assert property (@(posedge clk) disable iff (por_evt)
        !(wr_en && !wr_data[BIT_PWF]) |=> $stable(st_q.flg[BIT_PWF]));
    // R8: without a write, bit 6 holds
    a_r8_gp_hold: assert property (@(posedge clk) disable iff (por_evt)
        !wr_en |=> $stable(st_q.gp));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
    parameter int DELAY_CYC = 4096
) (
    input  logic       clk,
    input  logic       por_evt,
    input  logic       bor_evt,
    input  logic       ext_evt,
    input  logic       wdt_evt,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       wdt_pulse,
    output logic       int_rst
);
    logic src_any;

    rc_wdt_pulse u_pulse (
        .clk     (clk),
        .por_evt (por_evt),
        .wdt_evt (wdt_evt),
        .pulse   (wdt_pulse)
    );

    assign src_any = por_evt | bor_evt | ext_evt | wdt_pulse;

    rc_release_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk     (clk),
        .src_any (src_any),
        .rst_out (int_rst)
    );

    rc_cause_flags u_flags (
        .clk     (clk),
        .por_evt (por_evt),
        .bor_evt (bor_evt),
        .ext_evt (ext_evt),
        .wdt_set (wdt_pulse),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    // R2: the falling edge of the watchdog pulse finds reset asserted
    a_r2_fall_holds: assert property (@(posedge clk) disable iff (por_evt)
        $fell(wdt_pulse) |-> int_rst);
    // R10: flags do not change merely because reset is released
    a_r10_flags_keep: assert property (@(posedge clk) disable iff (por_evt)
        ($fell(int_rst) && !$past(wr_en) && !$past(bor_evt) && !$past(ext_evt))
        |-> $stable(rd_data));
endmodule

// File: tb/sim_rst_cause_ctrl.sv
module sim_rst_cause_ctrl;
    localparam int CLK_PER = 10;
    localparam int DLY     = 4;

    logic       clk = 1'b0;
    logic       por_evt = 1'b1, bor_evt = 1'b0, ext_evt = 1'b0, wdt_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       wdt_pulse, int_rst;

    int n_run = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    rst_cause_ctrl #(.DELAY_CYC(DLY)) u0 (
        .clk(clk), .por_evt(por_evt), .bor_evt(bor_evt), .ext_evt(ext_evt),
        .wdt_evt(wdt_evt), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wdt_pulse(wdt_pulse), .int_rst(int_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // hold a source for len cycles, then count int_rst-high samples
    task automatic src_run(input int which, input int len, output int hi_cnt);
        hi_cnt = 0;
        for (int k = 0; k < len; k++) begin
            if (which == 0) bor_evt = 1'b1;
            else            ext_evt = 1'b1;
            @(negedge clk);
            if (int_rst) hi_cnt++;
        end
        bor_evt = 1'b0; ext_evt = 1'b0;
        for (int k = 0; k < 3 * DLY; k++) begin
            @(negedge clk);
            if (int_rst) hi_cnt++;
        end
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        int hc;
        int pulses;
        int first_rst;
        @(negedge clk);
        por_evt = 1'b0;
        // R5 R3: power-on state
        chk("R5 por flags", rd_data, 8'h01);
        chk("R9 rst during por", int_rst, 1);
        hc = 1;
        for (int k = 0; k < 3 * DLY; k++) begin
            @(negedge clk);
            if (int_rst) hc++;
        end
        chk("R9 por release", hc, DLY + 1);

        // R6: write one leaves power-on flag; zero clears it
        wr(8'h01);
        chk("R6 write one keeps", rd_data, 8'h01);
        wr(8'h00);
        chk("R6 write zero clears", rd_data, 8'h00);

        // R9 R4: brown-out and external sweeps over hold length
        for (int len = 1; len <= 3; len++) begin
            src_run(0, len, hc);
            chk("R9 bor hold", hc, len + DLY);
            chk("R4 bor flag", rd_data, 8'h04);
            wr(8'h00);
            src_run(1, len, hc);
            chk("R9 ext hold", hc, len + DLY);
            chk("R4 ext flag", rd_data, 8'h02);
            chk("R10 ext flag after release", int_rst, 0);
            wr(8'h00);
        end

        // R1 R2: watchdog strobe held for several lengths
        for (int len = 1; len <= 4; len++) begin
            pulses = 0; first_rst = -1; hc = 0;
            wdt_evt = 1'b1;
            for (int k = 0; k < len + 3 * DLY; k++) begin
                if (k == len) wdt_evt = 1'b0;
                @(negedge clk);
                if (wdt_pulse) begin
                    pulses++;
                    chk("R1 pulse cycle", k, 0);
                end
                if (int_rst) begin
                    hc++;
                    if (first_rst < 0) first_rst = k;
                end
            end
            chk("R1 one pulse", pulses, 1);
            chk("R2 starts at fall", first_rst, 1);
            chk("R2 hold length", hc, DLY + 1);
            chk("R4 wdt flag", rd_data, 8'h08);
            wr(8'h00);
        end

        // R4: accumulation without clearing
        src_run(0, 1, hc);
        src_run(1, 1, hc);
        wdt_evt = 1'b1; @(negedge clk); wdt_evt = 1'b0;
        repeat (3 * DLY) @(negedge clk);
        chk("R4 accumulate", rd_data, 8'h0E);

        // R6 R8: write ones keeps flags and sets gp
        wr(8'hFF);
        chk("R6 ones no effect", rd_data, 8'h4E);
        chk("R3 unused zero", rd_data & 8'hB0, 0);
        // R8 gp survives a brown-out reset
        src_run(0, 2, hc);
        chk("R8 gp kept over reset", rd_data, 8'h4E);
        wr(8'h4A);
        chk("R6 partial clear", rd_data, 8'h4A);
        wr(8'h00);
        chk("R8 gp cleared", rd_data, 8'h00);

        // R7: set and clear same cycle
        wr(8'hFF);
        bor_evt = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        bor_evt = 1'b0; wr_en = 1'b0;
        chk("R7 set beats clear", rd_data, 8'h04);
        chk("R10 readable in reset", int_rst, 1);

        // R5: power-on wipes other flags and gp
        src_run(1, 1, hc);
        wdt_evt = 1'b1; @(negedge clk); wdt_evt = 1'b0;
        wr(8'h40);
        src_run(0, 1, hc);
        wdt_evt = 1'b1; @(negedge clk); wdt_evt = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 before por", rd_data, 8'h4C);
        por_evt = 1'b1; @(negedge clk); por_evt = 1'b0;
        chk("R5 por clears others", rd_data, 8'h01);
        chk("R9 rst on por", int_rst, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule